// File: doc/BRIEF.md
# Escalating Watchdog Timer

The watchdog counts a pre-scaled tick in a 10-bit up counter. When the count reaches a compare value set by software, the counter returns to zero, and the block takes the action chosen by a 2-bit mode field. It can raise a one-cycle reset request. It can set a sticky flag that drives a non-maskable interrupt line. In the escalation mode it raises the interrupt on one timeout and the reset on the next, unless software clears the counter in between. Software services the watchdog by pulsing the counter-clear strobe before the compare value is reached.

The counting rate comes from one of four externally supplied source enables, selected by 2 bits. That rate is then divided by 1, 2, 4 or 8. The source select, the divide select and the debug-run bit are held behind a lock, and they can be written only while the last key written equals 16'h0096. A 4-bit run field stops the counter only at the exact value 4'b1010. While the processor is halted for debug and debug-run is 0, the prescaler and the counter hold their state. The whole block runs on a single system clock.

Top module: `wdt_escalate`

## Requirements
- R1: Each tick adds one to `count`. A tick at which `count` equals `ctl_cmp` sets `count` to 0 instead. With divide select 0 and all source enables high, a tick occurs every clock.
- R2: The counter advances only while the stored run field differs from 4'b1010. Any other value lets it run. After reset the run field is 4'b1010, so the counter is stopped.
- R3: Mode 2'b00 and mode 2'b11 select reset-only. A match pulses `rst_req` high for one cycle, in the cycle after the matching edge, and `nmi` stays unaffected.
- R4: Mode 2'b01 selects interrupt-only. A match sets the status flag, which drives `nmi`, and `rst_req` stays low.
- R5: Mode 2'b10 selects escalation. The first match sets the status flag and arms escalation. The next match, if `cnt_clr` did not intervene, pulses `rst_req` and disarms.
- R6: `cnt_clr` zeroes the counter and the prescaler, and disarms a pending escalation. A match cannot occur in the cycle that `cnt_clr` is high.
- R7: The status flag stays set until `stat_clr` is pulsed. If a set and a clear land on the same edge, the set wins.
- R8: The prescaler advances on each cycle where `src_en[cfg_src_q]` is high and counting is allowed. Divide select d gives one tick for every 2^d such cycles.
- R9: When `dbg_mode` is 1 and the stored debug-run bit is 0, the prescaler and the counter freeze, and they resume afterwards. When debug-run is 1, counting goes on.
- R10: A `cfg_wr` takes effect only if the unlock state is set. A `key_wr` sets the unlock state when `key_data` is 16'h0096 and clears it for any other value. After reset the block is locked and the configuration is all zero.
- R11: After reset, `count` is 0, and `nmi`, `rst_req` and `unlocked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write strobe for the protection key |
| key_data | input | 16 | Protection key value |
| cfg_wr | input | 1 | Write strobe for the clock configuration |
| cfg_src | input | 2 | Source enable select |
| cfg_div | input | 2 | Divide select (ratio 2^value) |
| cfg_dbg_run | input | 1 | Keep counting during debug halt |
| ctl_wr | input | 1 | Write strobe for run, mode and compare |
| ctl_run | input | 4 | Run field, 4'b1010 stops |
| ctl_mode | input | 2 | Timeout action select |
| ctl_cmp | input | 10 | Compare value |
| cnt_clr | input | 1 | Counter-clear (service) strobe |
| stat_clr | input | 1 | Clear strobe for the interrupt status |
| dbg_mode | input | 1 | Processor is halted for debug |
| src_en | input | 4 | Externally supplied clock-source enables |
| nmi | output | 1 | Non-maskable interrupt, high while status is set |
| rst_req | output | 1 | One-cycle reset request |
| count | output | 10 | Current counter value |
| unlocked | output | 1 | Configuration unlock state |
| cfg_src_q | output | 2 | Stored source select |
| cfg_div_q | output | 2 | Stored divide select |
| cfg_dbg_q | output | 1 | Stored debug-run bit |

## Verification
With every source enable held high at divide 1, one clock equals one tick. This pattern separates off-by-one faults in the compare and wrap logic, in each of the three action modes. Random source-enable patterns at divide ratios 4 and 8 check that only the selected enable advances the prescaler, and that the ratio is applied correctly. The escalation sequence is run twice: left alone, where the reset must follow the interrupt one period later, and serviced between matches, where it must not. Writes made while locked, debug halts with and without debug-run, and run values other than 4'b1010 each tell a correct gating condition apart from one that is missing or inverted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_RST  = 2'b00,
    MODE_NMI  = 2'b01,
    MODE_ESC  = 2'b10,
    MODE_RST2 = 2'b11
  } wdt_mode_e;

  localparam logic [15:0] UNLOCK_KEY = 16'h0096;
  localparam logic [3:0]  RUN_STOP   = 4'b1010;
endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
  parameter int KEY_W = 16,
  parameter int SRC_W = 2,
  parameter int DIV_W = 2,
  parameter logic [KEY_W-1:0] KEY = 16'h0096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             cfg_wr,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_dbg_run,
  output logic             unlocked,
  output logic [SRC_W-1:0] src_q,
  output logic [DIV_W-1:0] div_q,
  output logic             dbg_run_q
);
  logic             unl_n;
  logic [SRC_W-1:0] src_n;
  logic [DIV_W-1:0] div_n;
  logic             dbg_n;
  logic             cfg_en;

  assign cfg_en = cfg_wr & unlocked;

  always_comb begin
    unl_n = unlocked;
    if (key_wr) unl_n = (key_data == KEY);
    src_n = src_q;
    div_n = div_q;
    dbg_n = dbg_run_q;
    if (cfg_en) begin
      src_n = cfg_src;
      div_n = cfg_div;
      dbg_n = cfg_dbg_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      src_q     <= '0;
      div_q     <= '0;
      dbg_run_q <= 1'b0;
    end else begin
      unlocked  <= unl_n;
      src_q     <= src_n;
      div_q     <= div_n;
      dbg_run_q <= dbg_n;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SRC_N = 4,
  parameter int DIV_W = 2,
  localparam int SRC_W = $clog2(SRC_N),
  localparam int PW = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_en,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             allow,
  input  logic             clr,
  output logic             tick
);
  logic [SRC_N-1:0] sel_hot;
  logic             src_pick;
  logic             adv;
  logic [PW:0]      mask_full;
  logic [PW-1:0]    mask;
  logic [PW-1:0]    pcnt, pcnt_n;

  for (genvar g = 0; g < SRC_N; g++) begin : g_sel
    assign sel_hot[g] = src_en[g] & (src_sel == SRC_W'(g));
  end

  assign src_pick  = |sel_hot;
  assign adv       = src_pick & allow;
  assign mask_full = ({{PW{1'b0}}, 1'b1} << div_sel) - 1'b1;
  assign mask      = mask_full[PW-1:0];
  assign tick      = adv & ((pcnt & mask) == mask);

  always_comb begin
    pcnt_n = pcnt;
    if (clr)      pcnt_n = '0;
    else if (adv) pcnt_n = pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt_n;
  end
endmodule

// File: rtl/wdt_period.sv
module wdt_period
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp,
  input  wdt_mode_e        mode,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             rst_req
);
  logic [CNT_W-1:0] count_n;
  logic             flag_n, pend, pend_n, rst_n_q;
  logic             hit, set_flag;

  assign hit = tick & ~clr & (count == cmp);

  always_comb begin
    count_n  = count;
    pend_n   = pend;
    set_flag = 1'b0;
    rst_n_q  = 1'b0;
    if (clr) begin
      count_n = '0;
      pend_n  = 1'b0;
    end else if (tick) begin
      if (hit) count_n = '0;
      else     count_n = count + 1'b1;
    end
    if (hit) begin
      unique case (mode)
        MODE_NMI: set_flag = 1'b1;
        MODE_ESC: begin
          if (pend) begin
            rst_n_q = 1'b1;
            pend_n  = 1'b0;
          end else begin
            set_flag = 1'b1;
            pend_n   = 1'b1;
          end
        end
        default: rst_n_q = 1'b1;
      endcase
    end
    if (set_flag)      flag_n = 1'b1;
    else if (stat_clr) flag_n = 1'b0;
    else               flag_n = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      flag    <= 1'b0;
      pend    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      count   <= count_n;
      flag    <= flag_n;
      pend    <= pend_n;
      rst_req <= rst_n_q;
    end
  end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SRC_N = 4,
  parameter int DIV_W = 2,
  parameter int KEY_W = 16,
  parameter int RUN_W = 4,
  localparam int SRC_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             cfg_wr,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_dbg_run,
  input  logic             ctl_wr,
  input  logic [RUN_W-1:0] ctl_run,
  input  logic [1:0]       ctl_mode,
  input  logic [CNT_W-1:0] ctl_cmp,
  input  logic             cnt_clr,
  input  logic             stat_clr,
  input  logic             dbg_mode,
  input  logic [SRC_N-1:0] src_en,
  output logic             nmi,
  output logic             rst_req,
  output logic [CNT_W-1:0] count,
  output logic             unlocked,
  output logic [SRC_W-1:0] cfg_src_q,
  output logic [DIV_W-1:0] cfg_div_q,
  output logic             cfg_dbg_q
);
  logic [1:0]       rsync;
  logic             irst_n;
  logic [RUN_W-1:0] run_q, run_n;
  wdt_mode_e        mode_q, mode_n;
  logic [CNT_W-1:0] cmp_q, cmp_n;
  logic             dbg_run_q;
  logic             allow, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign irst_n = rsync[1];

  always_comb begin
    run_n  = run_q;
    mode_n = mode_q;
    cmp_n  = cmp_q;
    if (ctl_wr) begin
      run_n  = ctl_run;
      mode_n = wdt_mode_e'(ctl_mode);
      cmp_n  = ctl_cmp;
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      run_q  <= RUN_W'(RUN_STOP);
      mode_q <= MODE_RST;
      cmp_q  <= '1;
    end else begin
      run_q  <= run_n;
      mode_q <= mode_n;
      cmp_q  <= cmp_n;
    end
  end

  wdt_keylock #(.KEY_W(KEY_W), .SRC_W(SRC_W), .DIV_W(DIV_W),
                .KEY(KEY_W'(UNLOCK_KEY))) u_lock (
    .clk(clk), .rst_n(irst_n), .key_wr(key_wr), .key_data(key_data),
    .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_div(cfg_div),
    .cfg_dbg_run(cfg_dbg_run), .unlocked(unlocked), .src_q(cfg_src_q),
    .div_q(cfg_div_q), .dbg_run_q(dbg_run_q)
  );
  assign cfg_dbg_q = dbg_run_q;

  assign allow = (run_q != RUN_W'(RUN_STOP)) & (~dbg_mode | dbg_run_q);

  wdt_prescaler #(.SRC_N(SRC_N), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(irst_n), .src_en(src_en), .src_sel(cfg_src_q),
    .div_sel(cfg_div_q), .allow(allow), .clr(cnt_clr), .tick(tick)
  );

  wdt_period #(.CNT_W(CNT_W)) u_per (
    .clk(clk), .rst_n(irst_n), .tick(tick), .clr(cnt_clr), .cmp(cmp_q),
    .mode(mode_q), .stat_clr(stat_clr), .count(count), .flag(nmi),
    .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_escalate_chk.sv
module wdt_escalate_chk #(
  parameter int CNT_W = 10,
  parameter int RUN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             nmi,
  input logic             rst_req,
  input logic             unlocked,
  input logic [1:0]       cfg_src_q,
  input logic [1:0]       cfg_div_q,
  input logic [RUN_W-1:0] run_q,
  input logic             dbg_mode,
  input logic             dbg_run_q,
  input logic             cnt_clr
);
  AST_WRAP_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> count == '0); // R1
  AST_NMI_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> count == '0); // R4
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == 4'b1010 && !cnt_clr) |=> $stable(count)); // R2
  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !dbg_run_q && !cnt_clr) |=> $stable(count)); // R9
  AST_LOCKED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(cfg_src_q)); // R10
  AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(cfg_div_q)); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0 && !rst_req)); // R6
endmodule

bind wdt_escalate wdt_escalate_chk #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .nmi(nmi), .rst_req(rst_req),
  .unlocked(unlocked), .cfg_src_q(cfg_src_q), .cfg_div_q(cfg_div_q),
  .run_q(run_q), .dbg_mode(dbg_mode), .dbg_run_q(dbg_run_q),
  .cnt_clr(cnt_clr)
);

// File: tb/test_wdt_escalate.sv
module test_wdt_escalate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_wr, cfg_wr, cfg_dbg_run, ctl_wr, cnt_clr, stat_clr, dbg_mode;
  logic [15:0] key_data;
  logic [1:0]  cfg_src, cfg_div, ctl_mode;
  logic [3:0]  ctl_run, src_en;
  logic [9:0]  ctl_cmp;
  logic        nmi, rst_req, unlocked, cfg_dbg_q;
  logic [9:0]  count;
  logic [1:0]  cfg_src_q, cfg_div_q;

  int checks = 0;
  int failures = 0;
  string cur_req = "R11";
  bit rnd_src = 0;

  always #4 clk = ~clk;

  wdt_escalate i_wdt_escalate (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
    .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_div(cfg_div),
    .cfg_dbg_run(cfg_dbg_run), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
    .ctl_mode(ctl_mode), .ctl_cmp(ctl_cmp), .cnt_clr(cnt_clr),
    .stat_clr(stat_clr), .dbg_mode(dbg_mode), .src_en(src_en), .nmi(nmi),
    .rst_req(rst_req), .count(count), .unlocked(unlocked),
    .cfg_src_q(cfg_src_q), .cfg_div_q(cfg_div_q), .cfg_dbg_q(cfg_dbg_q)
  );

  // behavioural reference
  int m_cnt, m_cmp, m_mode, m_run, m_src, m_div, m_dbg, m_presc;
  bit m_unl, m_flag, m_pend, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 1023; m_mode = 0; m_run = 10; m_src = 0; m_div = 0;
      m_dbg = 0; m_presc = 0; m_unl = 0; m_flag = 0; m_pend = 0; m_rst = 0;
    end else begin
      bit adv, tick, setf;
      int mask;
      adv  = src_en[m_src] && (m_run != 10) && (!dbg_mode || m_dbg != 0);
      mask = (1 << m_div) - 1;
      tick = adv && ((m_presc & mask) == mask);
      m_rst = 0;
      setf = 0;
      if (cnt_clr) begin
        m_presc = 0; m_cnt = 0; m_pend = 0;
      end else begin
        if (adv) m_presc = (m_presc + 1) % 8;
        if (tick) begin
          if (m_cnt == m_cmp) begin
            m_cnt = 0;
            if (m_mode == 1) setf = 1;
            else if (m_mode == 2) begin
              if (m_pend) begin m_rst = 1; m_pend = 0; end
              else begin setf = 1; m_pend = 1; end
            end else m_rst = 1;
          end else m_cnt = m_cnt + 1;
        end
      end
      if (setf) m_flag = 1;
      else if (stat_clr) m_flag = 0;
      if (cfg_wr && m_unl) begin
        m_src = cfg_src; m_div = cfg_div; m_dbg = cfg_dbg_run;
      end
      if (key_wr) m_unl = (key_data == 16'h0096);
      if (ctl_wr) begin
        m_run = ctl_run; m_mode = ctl_mode; m_cmp = ctl_cmp;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "count", count, m_cnt);
    chk(cur_req, "nmi", nmi, m_flag);
    chk(cur_req, "rst_req", rst_req, m_rst);
    chk(cur_req, "unlocked", unlocked, m_unl);
    chk(cur_req, "cfg_src", cfg_src_q, m_src);
    chk(cur_req, "cfg_div", cfg_div_q, m_div);
    chk(cur_req, "cfg_dbg", cfg_dbg_q, m_dbg);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      compare();
      key_wr = 0; cfg_wr = 0; ctl_wr = 0; cnt_clr = 0; stat_clr = 0;
      if (rnd_src) src_en = 4'($urandom);
    end
  endtask

  task automatic wkey(logic [15:0] k);
    key_wr = 1; key_data = k; step();
  endtask

  task automatic wcfg(logic [1:0] s, logic [1:0] d, logic b);
    cfg_wr = 1; cfg_src = s; cfg_div = d; cfg_dbg_run = b; step();
  endtask

  task automatic wctl(logic [3:0] r, logic [1:0] m, logic [9:0] c);
    ctl_wr = 1; ctl_run = r; ctl_mode = m; ctl_cmp = c; step();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired R11 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int seen_rst, seen_nmi, hold;
    rst_n = 0; key_wr = 0; cfg_wr = 0; ctl_wr = 0; cnt_clr = 0; stat_clr = 0;
    dbg_mode = 0; key_data = 0; cfg_src = 0; cfg_div = 0; cfg_dbg_run = 0;
    ctl_run = 4'hA; ctl_mode = 0; ctl_cmp = 0; src_en = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "count at reset", count, 0);
    chk("R11", "nmi at reset", nmi, 0);
    chk("R11", "rst_req at reset", rst_req, 0);
    chk("R11", "unlocked at reset", unlocked, 0);
    rst_n = 1;
    step(3);

    // R2: stopped out of reset
    cur_req = "R2";
    step(8);
    chk("R2", "count stays 0 while stopped", count, 0);

    // R10: writes while locked are ignored
    cur_req = "R10";
    wcfg(2'd1, 2'd2, 1'b1);
    chk("R10", "locked cfg_src", cfg_src_q, 0);
    chk("R10", "locked cfg_div", cfg_div_q, 0);
    wkey(16'h0096);
    chk("R10", "unlocked after key", unlocked, 1);
    wcfg(2'd0, 2'd0, 1'b0);
    wkey(16'h1234);
    chk("R10", "relocked after wrong key", unlocked, 0);
    wcfg(2'd3, 2'd3, 1'b1);
    chk("R10", "relocked cfg_div", cfg_div_q, 0);

    // R1/R3: reset-only mode, every clock a tick
    cur_req = "R3";
    wctl(4'h5, 2'b00, 10'd5);
    seen_rst = 0;
    for (int i = 0; i < 30; i++) begin step(); seen_rst += rst_req; end
    chk("R3", "reset pulses in 30 ticks", seen_rst, 5);
    chk("R3", "nmi stays low", nmi, 0);
    cur_req = "R1";
    wctl(4'h0, 2'b11, 10'd2);
    step(20);

    // R2: stop value holds the count, other values run
    cur_req = "R2";
    wctl(4'hA, 2'b01, 10'd9);
    hold = count;
    step(6);
    chk("R2", "stopped count holds", count, hold);
    wctl(4'hB, 2'b01, 10'd9);
    step(3);

    // R4/R7: interrupt-only and sticky status
    cur_req = "R4";
    cnt_clr = 1; step();
    step(12);
    chk("R4", "nmi set after match", nmi, 1);
    cur_req = "R7";
    step(15);
    chk("R7", "nmi sticky", nmi, 1);
    stat_clr = 1; step();
    chk("R7", "nmi cleared", nmi, 0);
    // clear on the same edge as a match: set wins
    cnt_clr = 1; step();
    step(9);
    stat_clr = 1; step();
    chk("R7", "set wins over clear", nmi, 1);
    stat_clr = 1; step();

    // R5: escalation left alone, then serviced
    cur_req = "R5";
    wctl(4'h3, 2'b10, 10'd4);
    cnt_clr = 1; step();
    seen_nmi = 0; seen_rst = 0;
    for (int i = 0; i < 6; i++) begin step(); seen_nmi += nmi; end
    chk("R5", "nmi after first match", nmi, 1);
    for (int i = 0; i < 6; i++) begin step(); seen_rst += rst_req; end
    chk("R5", "reset after second match", seen_rst, 1);
    stat_clr = 1; step();
    cur_req = "R6";
    cnt_clr = 1; step();
    step(6);
    chk("R6", "nmi on first match again", nmi, 1);
    cnt_clr = 1; step();
    seen_rst = 0;
    for (int i = 0; i < 5; i++) begin step(); seen_rst += rst_req; end
    chk("R6", "no reset after service", seen_rst, 0);
    stat_clr = 1; step();

    // R8: divided, random source enables
    cur_req = "R8";
    wctl(4'h1, 2'b00, 10'd7);
    wkey(16'h0096);
    wcfg(2'd2, 2'd2, 1'b0);
    rnd_src = 1;
    step(300);
    wcfg(2'd1, 2'd3, 1'b0);
    step(400);
    wcfg(2'd0, 2'd1, 1'b0);
    step(200);
    rnd_src = 0; src_en = 4'hF;
    wcfg(2'd0, 2'd0, 1'b0);
    step(5);

    // R9: debug freeze and debug run
    cur_req = "R9";
    wctl(4'h1, 2'b01, 10'd300);
    dbg_mode = 1;
    step();
    hold = count;
    step(10);
    chk("R9", "frozen in debug", count, hold);
    dbg_mode = 0;
    step(4);
    chk("R9", "resumes after debug", count, hold + 4);
    wcfg(2'd0, 2'd0, 1'b1);
    dbg_mode = 1;
    hold = count;
    step(10);
    chk("R9", "runs in debug with run bit", count, hold + 10);
    dbg_mode = 0;
    wkey(16'h0000);
    step(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule